// File: doc/BRIEF.md
# Drive Timing Clock Converter

This block turns the three timing figures of a disk-interface transfer mode (address setup, data pulse width and full cycle length, all in nanoseconds) into whole bus-clock counts for both drives sharing one channel, at a bus frequency given in MHz. Each count is rounded up, so a timing is never shortened, and then limited to the range the timing registers can hold. The recovery count comes from the part of the cycle left over after setup and pulse; if setup and pulse together already fill the cycle, the leftover is taken as zero.

The host loads the inputs and pulses `start_i`. The block captures everything in that cycle and converts the six values one after another through a shared restoring divider by 1000. It then packs one cycle byte per drive and one shared control byte, and raises `done_o` for a single cycle. A drive marked absent is given the smallest legal timings. Because both drives use a single address-setup value, the control byte holds the larger of the two address counts. The outputs hold their values until the next completion.

Top module: `ptc_ns_clock_calc`

## Requirements
- R1: The data count of a drive is ceil(active_ns × mhz / 1000), limited to 1..16, and appears in bits 7:4 of that drive's cycle byte as count − 1. An exact multiple is not rounded up (75 ns at 40 MHz gives 3).
- R2: The recovery count of a drive is ceil(rec_ns × mhz / 1000), with rec_ns = cycle_ns − setup_ns − active_ns, limited to 2..17. It appears in bits 3:0 of the cycle byte as count − 2.
- R3: The address count of a drive is ceil(setup_ns × mhz / 1000), limited to 1..4. Bits 5:4 of the control byte hold (larger of the two drives' address counts) − 1.
- R4: Bit 6 of the control byte is the prefetch enable (1 with default parameters). Bits 3:1 hold the ready-wait value minus 2 (0 with default parameters). Bits 7 and 0 are 0.
- R5: A drive whose present bit is 0 uses address 1, data 1 and recovery 2. Its cycle byte is therefore 0x00, and it adds an address count of 1 to the maximum.
- R6: `done_o` is high for exactly one cycle per accepted start. The three output bytes change only in the cycle where `done_o` is high.
- R7: A `start_i` pulse that arrives while a conversion is running is ignored. The result still reflects the inputs captured at the accepted start, and no extra `done_o` pulse follows.
- R8: While `rst` is high, and after it is released, all output bytes are 0x00 and `done_o` is 0 until the first conversion completes.
- R9: When setup_ns + active_ns is at least cycle_ns, the recovery time is taken as 0 ns, so the recovery count is 2 (field value 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Capture inputs and begin a conversion (ignored while busy) |
| present_i | input | 2 | Bit n set when drive n is attached |
| mhz_i | input | MHZ_W | Bus frequency in MHz |
| setup0_ns_i | input | NS_W | Drive 0 address setup, ns |
| active0_ns_i | input | NS_W | Drive 0 data pulse, ns |
| cycle0_ns_i | input | NS_W | Drive 0 full cycle, ns |
| setup1_ns_i | input | NS_W | Drive 1 address setup, ns |
| active1_ns_i | input | NS_W | Drive 1 data pulse, ns |
| cycle1_ns_i | input | NS_W | Drive 1 full cycle, ns |
| cycle_byte0_o | output | 8 | Drive 0 packed data/recovery byte |
| cycle_byte1_o | output | 8 | Drive 1 packed data/recovery byte |
| misc_byte_o | output | 8 | Shared address/ready-wait/prefetch byte |
| done_o | output | 1 | One-cycle result-ready pulse |

## Verification
The assertions assume that the internal divider is started only when it is idle. They also assume that the numerator, ns × mhz + 999, fits the divider width given by the NS_W and MHZ_W parameters. Input bounds at the ports enforce both, and the sequencer issues one division at a time. The stimulus never drives values wider than the ports. It pulses `start_i` again during a conversion to exercise R7, and it sweeps the five standard transfer-mode timing sets, six bus frequencies and every presence pattern. Timing sets chosen so that setup plus pulse exceeds the cycle, or so that every field hits its upper or lower limit, cover the clamping and zero-floor paths.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    // Legal clock-count ranges of the timing fields
    localparam int ADDR_MIN = 1;
    localparam int ADDR_MAX = 4;
    localparam int DATA_MIN = 1;
    localparam int DATA_MAX = 16;
    localparam int REC_MIN  = 2;
    localparam int REC_MAX  = 17;

    localparam int FIELD_W  = 5;
    localparam int NUM_FLD  = 3;

    typedef enum logic [1:0] {
        FLD_ADDR = 2'd0,
        FLD_DATA = 2'd1,
        FLD_REC  = 2'd2
    } field_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_PACK  = 2'd3
    } state_e;

    typedef struct packed {
        logic [FIELD_W-1:0] addr;
        logic [FIELD_W-1:0] data;
        logic [FIELD_W-1:0] rec;
    } drive_clk_t;

    function automatic drive_clk_t absent_clks();
        drive_clk_t c;
        c.addr = FIELD_W'(ADDR_MIN);
        c.data = FIELD_W'(DATA_MIN);
        c.rec  = FIELD_W'(REC_MIN);
        return c;
    endfunction

    // Pack data and recovery counts into one cycle byte
    function automatic logic [7:0] cycle_byte(drive_clk_t c);
        logic [FIELD_W-1:0] d_off;
        logic [FIELD_W-1:0] r_off;
        d_off = c.data - FIELD_W'(DATA_MIN);
        r_off = c.rec  - FIELD_W'(REC_MIN);
        return {d_off[3:0], r_off[3:0]};
    endfunction

    function automatic field_e next_field(field_e f);
        case (f)
            FLD_ADDR: return FLD_DATA;
            FLD_DATA: return FLD_REC;
            default:  return FLD_ADDR;
        endcase
    endfunction

endpackage

// File: rtl/ptc_restoring_div.sv
module ptc_restoring_div #(
    parameter int NUM_W   = 18,
    parameter int DIVISOR = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    input  logic [NUM_W-1:0] num_i,
    output logic [NUM_W-1:0] quo_o,
    output logic             valid_o
);
    localparam int DIV_W = $clog2(DIVISOR) + 1;
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [DIV_W-1:0] rem_q;
    logic [NUM_W-1:0] quo_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    logic [DIV_W-1:0] trial;
    logic             take;
    logic [DIV_W-1:0] rem_next;

    always_comb begin
        trial    = {rem_q[DIV_W-2:0], quo_q[NUM_W-1]};
        take     = (trial >= DIV_W'(DIVISOR));
        rem_next = take ? (trial - DIV_W'(DIVISOR)) : trial;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q   <= '0;
            quo_q   <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (go_i) begin
                rem_q  <= '0;
                quo_q  <= num_i;
                cnt_q  <= CNT_W'(NUM_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= rem_next;
                quo_q <= {quo_q[NUM_W-2:0], take};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q  <= 1'b0;
                    valid_o <= 1'b1;
                end
            end
        end
    end

    assign quo_o = quo_q;

    // Remainder of a finished division lies below the divisor (rounding of R1)
    assert_rem_below_divisor_R1: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (rem_q < DIV_W'(DIVISOR)));

    // A new division is only launched while idle (R1)
    assert_go_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
        go_i |-> !busy_q);

endmodule

// File: rtl/ptc_field_clamp.sv
module ptc_field_clamp #(
    parameter int IN_W  = 18,
    parameter int OUT_W = 5,
    parameter int LO    = 1,
    parameter int HI    = 4
) (
    input  logic [IN_W-1:0]  val_i,
    output logic [OUT_W-1:0] val_o
);
    always_comb begin
        if (val_i < IN_W'(LO))
            val_o = OUT_W'(LO);
        else if (val_i > IN_W'(HI))
            val_o = OUT_W'(HI);
        else
            val_o = val_i[OUT_W-1:0];
    end
endmodule

// File: rtl/ptc_byte_pack.sv
module ptc_byte_pack
    import ptc_pkg::*;
#(
    parameter bit PREFETCH_EN = 1'b1,
    parameter int READY_WAIT  = 2
) (
    input  drive_clk_t  clk0_i,
    input  drive_clk_t  clk1_i,
    input  logic [1:0]  present_i,
    output logic [7:0]  cycle0_o,
    output logic [7:0]  cycle1_o,
    output logic [7:0]  misc_o
);
    drive_clk_t eff [2];
    logic [FIELD_W-1:0] ax;
    logic [FIELD_W-1:0] ax_off;
    logic [2:0]         rdy_off;

    always_comb begin
        eff[0] = present_i[0] ? clk0_i : absent_clks();
        eff[1] = present_i[1] ? clk1_i : absent_clks();
        ax      = (eff[0].addr > eff[1].addr) ? eff[0].addr : eff[1].addr;
        ax_off  = ax - FIELD_W'(ADDR_MIN);
        rdy_off = 3'(READY_WAIT - 2);
        cycle0_o = cycle_byte(eff[0]);
        cycle1_o = cycle_byte(eff[1]);
        misc_o   = {1'b0, PREFETCH_EN, ax_off[1:0], rdy_off, 1'b0};
    end
endmodule

// File: rtl/ptc_ns_clock_calc.sv
module ptc_ns_clock_calc
    import ptc_pkg::*;
#(
    parameter int NS_W        = 10,
    parameter int MHZ_W       = 7,
    parameter int DIVISOR     = 1000,
    parameter bit PREFETCH_EN = 1'b1,
    parameter int READY_WAIT  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [1:0]       present_i,
    input  logic [MHZ_W-1:0] mhz_i,
    input  logic [NS_W-1:0]  setup0_ns_i,
    input  logic [NS_W-1:0]  active0_ns_i,
    input  logic [NS_W-1:0]  cycle0_ns_i,
    input  logic [NS_W-1:0]  setup1_ns_i,
    input  logic [NS_W-1:0]  active1_ns_i,
    input  logic [NS_W-1:0]  cycle1_ns_i,
    output logic [7:0]       cycle_byte0_o,
    output logic [7:0]       cycle_byte1_o,
    output logic [7:0]       misc_byte_o,
    output logic             done_o
);
    localparam int NUM_W = NS_W + MHZ_W + 1;
    localparam int LO_TAB [NUM_FLD] = '{ADDR_MIN, DATA_MIN, REC_MIN};
    localparam int HI_TAB [NUM_FLD] = '{ADDR_MAX, DATA_MAX, REC_MAX};

    state_e            state_q;
    field_e            fld_q;
    logic              drv_q;
    logic [NS_W-1:0]   setup_q [2];
    logic [NS_W-1:0]   act_q   [2];
    logic [NS_W-1:0]   cyc_q   [2];
    logic [MHZ_W-1:0]  mhz_q;
    logic [1:0]        pres_q;
    drive_clk_t        clk_q   [2];

    logic [NS_W+1:0]   spent_ns;
    logic [NS_W-1:0]   rec_ns;
    logic [NS_W-1:0]   ns_sel;
    logic [NUM_W-1:0]  num;
    logic              div_go;
    logic [NUM_W-1:0]  quo;
    logic              div_valid;
    logic [FIELD_W-1:0] clamped [NUM_FLD];
    logic [7:0]        pk_cyc0, pk_cyc1, pk_misc;

    // Numerator for the field now being converted; leftover time floors at zero
    always_comb begin
        spent_ns = (NS_W+2)'(setup_q[drv_q]) + (NS_W+2)'(act_q[drv_q]);
        if ((NS_W+2)'(cyc_q[drv_q]) > spent_ns)
            rec_ns = NS_W'((NS_W+2)'(cyc_q[drv_q]) - spent_ns);
        else
            rec_ns = '0;
        case (fld_q)
            FLD_ADDR: ns_sel = setup_q[drv_q];
            FLD_DATA: ns_sel = act_q[drv_q];
            default:  ns_sel = rec_ns;
        endcase
        num    = NUM_W'(ns_sel) * NUM_W'(mhz_q) + NUM_W'(DIVISOR - 1);
        div_go = (state_q == ST_ISSUE);
    end

    ptc_restoring_div #(
        .NUM_W   (NUM_W),
        .DIVISOR (DIVISOR)
    ) u_div (
        .clk     (clk),
        .rst     (rst),
        .go_i    (div_go),
        .num_i   (num),
        .quo_o   (quo),
        .valid_o (div_valid)
    );

    for (genvar g = 0; g < NUM_FLD; g++) begin : g_clamp
        ptc_field_clamp #(
            .IN_W  (NUM_W),
            .OUT_W (FIELD_W),
            .LO    (LO_TAB[g]),
            .HI    (HI_TAB[g])
        ) u_clamp (
            .val_i (quo),
            .val_o (clamped[g])
        );
    end

    ptc_byte_pack #(
        .PREFETCH_EN (PREFETCH_EN),
        .READY_WAIT  (READY_WAIT)
    ) u_pack (
        .clk0_i    (clk_q[0]),
        .clk1_i    (clk_q[1]),
        .present_i (pres_q),
        .cycle0_o  (pk_cyc0),
        .cycle1_o  (pk_cyc1),
        .misc_o    (pk_misc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            fld_q         <= FLD_ADDR;
            drv_q         <= 1'b0;
            mhz_q         <= '0;
            pres_q        <= '0;
            for (int i = 0; i < 2; i++) begin
                setup_q[i] <= '0;
                act_q[i]   <= '0;
                cyc_q[i]   <= '0;
                clk_q[i]   <= '0;
            end
            cycle_byte0_o <= '0;
            cycle_byte1_o <= '0;
            misc_byte_o   <= '0;
            done_o        <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        setup_q[0] <= setup0_ns_i;
                        act_q[0]   <= active0_ns_i;
                        cyc_q[0]   <= cycle0_ns_i;
                        setup_q[1] <= setup1_ns_i;
                        act_q[1]   <= active1_ns_i;
                        cyc_q[1]   <= cycle1_ns_i;
                        mhz_q      <= mhz_i;
                        pres_q     <= present_i;
                        drv_q      <= 1'b0;
                        fld_q      <= FLD_ADDR;
                        state_q    <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (div_valid) begin
                        case (fld_q)
                            FLD_ADDR: clk_q[drv_q].addr <= clamped[0];
                            FLD_DATA: clk_q[drv_q].data <= clamped[1];
                            default:  clk_q[drv_q].rec  <= clamped[2];
                        endcase
                        if (drv_q && fld_q == FLD_REC) begin
                            state_q <= ST_PACK;
                        end else begin
                            if (fld_q == FLD_REC) drv_q <= 1'b1;
                            fld_q   <= next_field(fld_q);
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: begin
                    cycle_byte0_o <= pk_cyc0;
                    cycle_byte1_o <= pk_cyc1;
                    misc_byte_o   <= pk_misc;
                    done_o        <= 1'b1;
                    state_q       <= ST_IDLE;
                end
            endcase
        end
    end

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_outputs_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(cycle_byte0_o) && $stable(cycle_byte1_o) && $stable(misc_byte_o)));

    assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && start_i) |=> ($stable(mhz_q) && $stable(pres_q)));

    assert_rec_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        (div_valid && fld_q == FLD_REC) |->
            (clamped[2] >= FIELD_W'(REC_MIN) && clamped[2] <= FIELD_W'(REC_MAX)));

    assert_misc_spare_bits_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (misc_byte_o[7] == 1'b0 && misc_byte_o[0] == 1'b0));

endmodule

// File: tb/ptc_ns_clock_calc_tb.sv
module ptc_ns_clock_calc_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [1:0] present_i = '0;
    logic [6:0] mhz_i = '0;
    logic [9:0] s0 = '0, a0 = '0, c0 = '0, s1 = '0, a1 = '0, c1 = '0;
    logic [7:0] cyc0, cyc1, misc;
    logic       done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ptc_ns_clock_calc u_dut (
        .clk (clk), .rst (rst), .start_i (start_i), .present_i (present_i),
        .mhz_i (mhz_i),
        .setup0_ns_i (s0), .active0_ns_i (a0), .cycle0_ns_i (c0),
        .setup1_ns_i (s1), .active1_ns_i (a1), .cycle1_ns_i (c1),
        .cycle_byte0_o (cyc0), .cycle_byte1_o (cyc1), .misc_byte_o (misc),
        .done_o (done)
    );

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int cdiv(int ns, int mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

    function automatic int lim(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (done) begin seen = 1'b1; break; end
        end
    endtask

    task automatic run(int mhz, int ps0, int pa0, int pc0, int ps1, int pa1, int pc1,
                       bit p0, bit p1);
        int ad [2], dd [2], rd [2], ax, rec;
        int st [2], ac [2], cy [2];
        bit pr [2];
        bit seen;
        st = '{ps0, ps1}; ac = '{pa0, pa1}; cy = '{pc0, pc1}; pr = '{p0, p1};
        for (int d = 0; d < 2; d++) begin
            rec = cy[d] - st[d] - ac[d];
            if (rec < 0) rec = 0;
            if (pr[d]) begin
                ad[d] = lim(cdiv(st[d], mhz), 1, 4);
                dd[d] = lim(cdiv(ac[d], mhz), 1, 16);
                rd[d] = lim(cdiv(rec, mhz), 2, 17);
            end else begin
                ad[d] = 1; dd[d] = 1; rd[d] = 2;
            end
        end
        ax = (ad[0] > ad[1]) ? ad[0] : ad[1];
        @(negedge clk);
        mhz_i = 7'(mhz); present_i = {p1, p0};
        s0 = 10'(ps0); a0 = 10'(pa0); c0 = 10'(pc0);
        s1 = 10'(ps1); a1 = 10'(pa1); c1 = 10'(pc1);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(seen);
        check("R6", int'(seen), 1, "done pulse seen");
        check("R1", int'(cyc0[7:4]), dd[0] - 1, "drive0 data field");
        check("R2", int'(cyc0[3:0]), rd[0] - 2, "drive0 recovery field");
        check("R1", int'(cyc1[7:4]), dd[1] - 1, "drive1 data field");
        check("R2", int'(cyc1[3:0]), rd[1] - 2, "drive1 recovery field");
        check("R3", int'(misc[5:4]), ax - 1, "shared address field");
        check("R4", int'(misc & 8'hCF), 8'h40, "fixed control bits");
        if (!p0) check("R5", int'(cyc0), 0, "absent drive0 byte");
        if (!p1) check("R5", int'(cyc1), 0, "absent drive1 byte");
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int st_t [5] = '{70, 50, 30, 30, 25};
        int ac_t [5] = '{165, 125, 100, 80, 70};
        int cy_t [5] = '{600, 383, 240, 180, 120};
        int mhz_t [6] = '{20, 25, 33, 40, 50, 66};
        bit seen;
        logic [7:0] h0, h1, hm;

        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8", int'(cyc0), 0, "reset cycle0");
        check("R8", int'(cyc1), 0, "reset cycle1");
        check("R8", int'(misc), 0, "reset misc");
        check("R8", int'(done), 0, "reset done");
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R8", int'(misc), 0, "misc after release");
        check("R8", int'(done), 0, "done after release");

        // Sweep: every mode pair, bus speeds, presence patterns (R1 R2 R3 R4 R5)
        for (int m = 0; m < 6; m++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    for (int p = 0; p < 4; p++)
                        run(mhz_t[m], st_t[i], ac_t[i], cy_t[i],
                            st_t[j], ac_t[j], cy_t[j], p[0], p[1]);

        // R1: exact multiple not rounded up: 75 ns at 40 MHz -> 3 clocks
        run(40, 30, 75, 300, 30, 76, 300, 1'b1, 1'b1);
        check("R1", int'(cyc0[7:4]), 2, "exact multiple data");
        check("R1", int'(cyc1[7:4]), 3, "just above multiple data");

        // R9: setup+active beyond cycle -> recovery 0 ns -> count 2
        run(40, 100, 200, 250, 100, 200, 300, 1'b1, 1'b1);
        check("R9", int'(cyc0[3:0]), 0, "negative leftover");
        check("R9", int'(cyc1[3:0]), 0, "zero leftover");

        // Upper and lower limits of every field
        run(127, 1023, 1023, 1023, 0, 0, 1023, 1'b1, 1'b1);
        check("R3", int'(misc[5:4]), 3, "address upper limit");
        check("R1", int'(cyc0[7:4]), 15, "data upper limit");
        check("R2", int'(cyc1[3:0]), 15, "recovery upper limit");
        check("R1", int'(cyc1[7:4]), 0, "data lower limit");

        // R6: outputs hold and done stays low after a completion
        h0 = cyc0; h1 = cyc1; hm = misc;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check("R6", int'(done), 0, "done after pulse");
        end
        check("R6", int'(cyc0), int'(h0), "hold cycle0");
        check("R6", int'(cyc1), int'(h1), "hold cycle1");
        check("R6", int'(misc), int'(hm), "hold misc");

        // R7: second start during a conversion is ignored
        @(negedge clk);
        mhz_i = 7'd20; present_i = 2'b11;
        s0 = 10'd70; a0 = 10'd165; c0 = 10'd600;
        s1 = 10'd70; a1 = 10'd165; c1 = 10'd600;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        mhz_i = 7'd66; s0 = 10'd25; a0 = 10'd70; c0 = 10'd120;
        present_i = 2'b00;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(seen);
        check("R7", int'(seen), 1, "first done");
        // 20 MHz: data ceil(3300/1000)=4 -> 3, rec ceil(7300/1000)=8 -> 6, addr 2 -> 1
        check("R7", int'(cyc0), 8'h36, "cycle0 from captured inputs");
        check("R7", int'(misc), 8'h50, "misc from captured inputs");
        seen = 1'b0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        check("R7", int'(seen), 0, "no extra done");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule